// File: doc/BRIEF.md
# Flash Status Register and Write Guard

This block keeps the eight-bit software status register of a serial flash device and decides whether a write-type command may go ahead. A command decoder upstream presents each finished command for one clock cycle, at the moment chip select rises. That presentation carries the opcode, the 24-bit target address (of which the array uses the low bits) and the single data byte that a status write carries. The write-protect pin is sampled in that same cycle. The busy flag of the array timer is a separate input, and a pulse marks the end of a byte program or an erase.

The block drives the status byte that a status read shifts out. It also drives a combinational grant for the command being presented: program, word-increment program, sector erase, block erase or chip erase. A third output tells the decoder whether the next status write would be armed.

Protection is described by a three-bit code that covers a power-of-two number of 64 KB blocks counted down from the top of the array. A lock bit freezes the register, but only while the write-protect pin is low.

Top module: `fsr_guard`

## Requirements
- R1: After reset the status byte reads 0x1C with the busy input low: bits 4..2 (protect code) are 111 and every other bit is 0. The armed output is 0.
- R2: The status byte is laid out as follows. Bit 7 is the lock bit. Bit 6 is the word-increment mode flag. Bit 5 always reads 0. Bits 4..2 hold the protect code. Bit 1 is the write-enable latch. Bit 0 follows the busy input in the same cycle.
- R3: Opcode 0x06 sets the write-enable latch. Opcode 0x04 clears both the latch and the word-increment flag. Both changes are visible the cycle after the command.
- R4: Opcodes 0x50 and 0x06 arm a status write. Any other presented command, 0x01 included, disarms it. The armed output shows this state from the cycle after the command.
- R5: A status write (opcode 0x01) that is not armed changes nothing. An accepted one copies data bit 7 to the lock bit and data bits 4..2 to the protect code, and clears the write-enable latch. It leaves every other bit unchanged.
- R6: When the write-protect input is low and the lock bit is 1, an armed status write changes nothing. When the lock bit is 0, one write may set the lock bit and change the protect code together.
- R7: When the write-protect input is high, the lock bit is ignored and an armed status write always takes effect.
- R8: The protect code maps to protected addresses as follows. Code 000 protects nothing. Code 001 protects 0x70000..0x7FFFF. Code 010 protects 0x60000..0x7FFFF. Code 011 protects 0x40000..0x7FFFF. Codes 1xx protect the whole array. Opcodes 0x02, 0xAD, 0x20 and 0xD8 are denied when they target a protected address.
- R9: Chip erase (opcode 0x60 or 0xC7) is granted only when the protect code is 000, whatever the address.
- R10: The grant output is high only while a command is presented, the write-enable latch is 1 and busy is 0. It is 0 for every opcode outside the six write-type opcodes.
- R11: A completion pulse clears the write-enable latch in the next cycle, unless 0x06 is presented in the same cycle.
- R12: A granted opcode 0xAD sets the word-increment flag (bit 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle strobe: a finished command is presented |
| cmd_op | input | 8 | Opcode of the presented command |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_data | input | 8 | Data byte of a status write |
| wp_n | input | 1 | Write-protect pin, sampled with cmd_valid |
| busy_i | input | 1 | Array operation in progress |
| op_done | input | 1 | Pulse: a byte program or an erase finished |
| status_o | output | 8 | Status byte for read-back |
| wr_allow | output | 1 | Grant for the presented write-type command |
| sr_armed | output | 1 | A status write presented next would be armed |

## Verification
The assertions assume three things about the inputs. The decoder presents at most one command per cycle. cmd_valid never stays high across two cycles for the same command. op_done is a single-cycle pulse, not a level. The stimulus keeps to this by always dropping cmd_valid and op_done one cycle after raising them. Random traffic keeps busy and completion independent of the command stream, so that the ordering between a completion and a write-enable in the same cycle is exercised. Directed sequences then walk each protect code across its block boundary, and test both settings of the write-protect pin with the lock bit set and clear.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int BP_W = 3;

    localparam logic [7:0] OP_WSR     = 8'h01;
    localparam logic [7:0] OP_PROG    = 8'h02;
    localparam logic [7:0] OP_WDIS    = 8'h04;
    localparam logic [7:0] OP_WEN     = 8'h06;
    localparam logic [7:0] OP_SERASE  = 8'h20;
    localparam logic [7:0] OP_ARM     = 8'h50;
    localparam logic [7:0] OP_CHIP_A  = 8'h60;
    localparam logic [7:0] OP_WINC    = 8'hAD;
    localparam logic [7:0] OP_CHIP_B  = 8'hC7;
    localparam logic [7:0] OP_BERASE  = 8'hD8;

    typedef enum logic [2:0] {
        K_OTHER,
        K_WEN,
        K_WDIS,
        K_ARM,
        K_WSR,
        K_ADDR_WR,
        K_CHIP,
        K_WINC
    } cmd_kind_e;

    typedef struct packed {
        logic            wel;
        logic            winc;
        logic [BP_W-1:0] bp;
        logic            lock;
    } sr_state_t;

    function automatic cmd_kind_e classify(input logic [7:0] op);
        cmd_kind_e k;
        case (op)
            OP_WEN:                        k = K_WEN;
            OP_WDIS:                       k = K_WDIS;
            OP_ARM:                        k = K_ARM;
            OP_WSR:                        k = K_WSR;
            OP_PROG, OP_SERASE, OP_BERASE: k = K_ADDR_WR;
            OP_CHIP_A, OP_CHIP_B:          k = K_CHIP;
            OP_WINC:                       k = K_WINC;
            default:                       k = K_OTHER;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/fsr_arm_track.sv
module fsr_arm_track
    import fsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_valid,
    input  cmd_kind_e kind,
    output logic      armed_o
);

    logic armed_d, armed_q;

    always_comb begin
        armed_d = armed_q;
        if (cmd_valid) begin
            armed_d = (kind == K_WEN) || (kind == K_ARM);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end

    assign armed_o = armed_q;

    // R4: an arming opcode leaves the next command armed
    p_arm_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (kind == K_ARM || kind == K_WEN) |=> armed_o);

    // R4: any other command disarms
    p_arm_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !(kind == K_ARM || kind == K_WEN) |=> !armed_o);

endmodule

// File: rtl/fsr_region_check.sv
module fsr_region_check
    import fsr_pkg::*;
#(
    parameter int NBLK_W = 3
) (
    input  logic [NBLK_W-1:0] blk_i,
    input  logic [BP_W-1:0]   bp_i,
    output logic              hit_o,
    output logic              any_o
);

    localparam int NBLK = 1 << NBLK_W;

    int shift;
    int top_cnt;

    always_comb begin
        shift   = 0;
        top_cnt = 0;
        hit_o   = 1'b0;
        if (bp_i == '0) begin
            hit_o = 1'b0;
        end else if (bp_i[BP_W-1]) begin
            hit_o = 1'b1;
        end else begin
            shift = int'(bp_i[BP_W-2:0]) - 1;
            if (shift >= NBLK_W) begin
                hit_o = 1'b1;
            end else begin
                top_cnt = 1 << shift;
                hit_o   = int'(blk_i) >= (NBLK - top_cnt);
            end
        end
    end

    assign any_o = (bp_i != '0);

endmodule

// File: rtl/fsr_status_core.sv
module fsr_status_core
    import fsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  cmd_kind_e       kind,
    input  logic            new_lock,
    input  logic [BP_W-1:0] new_bp,
    input  logic            armed_i,
    input  logic            wp_n,
    input  logic            op_done,
    input  logic            grant_i,
    output sr_state_t       state_o
);

    sr_state_t st_d, st_q;
    logic      wsr_ok;

    assign wsr_ok = armed_i && (wp_n || !st_q.lock);

    always_comb begin
        st_d = st_q;
        if (op_done) begin
            st_d.wel = 1'b0;
        end
        if (cmd_valid) begin
            case (kind)
                K_WEN: begin
                    st_d.wel = 1'b1;
                end
                K_WDIS: begin
                    st_d.wel  = 1'b0;
                    st_d.winc = 1'b0;
                end
                K_WSR: begin
                    if (wsr_ok) begin
                        st_d.bp   = new_bp;
                        st_d.lock = new_lock;
                        st_d.wel  = 1'b0;
                    end
                end
                K_WINC: begin
                    if (grant_i) st_d.winc = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wel  <= 1'b0;
            st_q.winc <= 1'b0;
            st_q.bp   <= '1;
            st_q.lock <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q;

    // R6: locked register with pin low is frozen
    p_locked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && kind == K_WSR && !wp_n && st_q.lock
        |=> $stable(st_q.bp) && $stable(st_q.lock));

    // R5: unarmed status write leaves protection untouched
    p_unarmed_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && kind == K_WSR && !armed_i
        |=> $stable(st_q.bp) && $stable(st_q.lock));

    // R11: completion clears the latch unless a write-enable coincides
    p_done_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        op_done && !(cmd_valid && kind == K_WEN) |=> !st_q.wel);

endmodule

// File: rtl/fsr_guard.sv
module fsr_guard
    import fsr_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int BLK_OFF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              wp_n,
    input  logic              busy_i,
    input  logic              op_done,
    output logic [7:0]        status_o,
    output logic              wr_allow,
    output logic              sr_armed
);

    localparam int NBLK_W = ADDR_W - BLK_OFF_W;

    cmd_kind_e kind;
    sr_state_t st;
    logic      prot_hit;
    logic      prot_any;
    logic      armed;
    logic      unused_bits;

    assign kind        = classify(cmd_op);
    assign unused_bits = ^{cmd_addr[BLK_OFF_W-1:0], cmd_data[6:5], cmd_data[1:0]};

    fsr_arm_track u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .kind      (kind),
        .armed_o   (armed)
    );

    fsr_region_check #(.NBLK_W(NBLK_W)) u_region (
        .blk_i (cmd_addr[ADDR_W-1:BLK_OFF_W]),
        .bp_i  (st.bp),
        .hit_o (prot_hit),
        .any_o (prot_any)
    );

    always_comb begin
        wr_allow = 1'b0;
        if (cmd_valid && st.wel && !busy_i) begin
            case (kind)
                K_ADDR_WR, K_WINC: wr_allow = !prot_hit;
                K_CHIP:            wr_allow = !prot_any;
                default:           wr_allow = 1'b0;
            endcase
        end
    end

    fsr_status_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .kind      (kind),
        .new_lock  (cmd_data[7]),
        .new_bp    (cmd_data[4:2]),
        .armed_i   (armed),
        .wp_n      (wp_n),
        .op_done   (op_done),
        .grant_i   (wr_allow),
        .state_o   (st)
    );

    assign status_o = {st.lock, st.winc, 1'b0, st.bp, st.wel, busy_i};
    assign sr_armed = armed;

    // R10: a grant needs the latch set and the array idle
    p_grant_needs_wel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_allow |-> status_o[1] && !status_o[0] && cmd_valid);

    // R9: chip erase granted only with no protection
    p_chip_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && kind == K_CHIP && wr_allow |-> status_o[4:2] == 3'b000);

    // R2: reserved bit reads zero
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[5]);

endmodule

// File: tb/fsr_guard_tb_top.sv
`timescale 1ns/1ps
module fsr_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [7:0]  cmd_op;
    logic [18:0] cmd_addr;
    logic [7:0]  cmd_data;
    logic        wp_n;
    logic        busy_i;
    logic        op_done;
    logic [7:0]  status_o;
    logic        wr_allow;
    logic        sr_armed;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic       m_wel, m_winc, m_lock, m_armed;
    logic [2:0] m_bp;

    always #4 clk = ~clk;

    fsr_guard dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n), .busy_i(busy_i),
        .op_done(op_done), .status_o(status_o), .wr_allow(wr_allow), .sr_armed(sr_armed)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_prot(input logic [18:0] a, input logic [2:0] bp);
        logic [2:0] blk;
        blk = a[18:16];
        if (bp == 3'b000) return 1'b0;
        if (bp[2]) return 1'b1;
        case (bp[1:0])
            2'd1:    return blk == 3'd7;
            2'd2:    return blk >= 3'd6;
            default: return blk >= 3'd4;
        endcase
    endfunction

    function automatic logic exp_allow(input logic [7:0] op, input logic [18:0] a,
                                       input logic wel, input logic [2:0] bp, input logic bsy);
        if (!wel || bsy) return 1'b0;
        case (op)
            8'h02, 8'hAD, 8'h20, 8'hD8: return !exp_prot(a, bp);
            8'h60, 8'hC7:               return bp == 3'b000;
            default:                    return 1'b0;
        endcase
    endfunction

    task automatic step(input logic v, input logic [7:0] op, input logic [18:0] a,
                        input logic [7:0] d, input logic wp, input logic bsy,
                        input logic dn, output logic got);
        logic al;
        @(negedge clk);
        check("R2 status layout", status_o, {m_lock, m_winc, 1'b0, m_bp, m_wel, busy_i});
        check("R4 armed state", sr_armed, m_armed);
        cmd_valid = v; cmd_op = op; cmd_addr = a; cmd_data = d;
        wp_n = wp; busy_i = bsy; op_done = dn;
        #1;
        al  = v ? exp_allow(op, a, m_wel, m_bp, bsy) : 1'b0;
        got = wr_allow;
        check("R10 grant", wr_allow, al);
        if (dn) m_wel = 1'b0;
        if (v) begin
            case (op)
                8'h06: m_wel = 1'b1;
                8'h04: begin m_wel = 1'b0; m_winc = 1'b0; end
                8'h01: if (m_armed && (wp || !m_lock)) begin
                    m_bp = d[4:2]; m_lock = d[7]; m_wel = 1'b0;
                end
                8'hAD: if (al) m_winc = 1'b1;
                default: ;
            endcase
            m_armed = (op == 8'h06) || (op == 8'h50);
        end
        @(posedge clk);
        #1;
        cmd_valid = 1'b0; op_done = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] op, input logic [18:0] a, input logic [7:0] d,
                       input logic wp, output logic got);
        step(1'b1, op, a, d, wp, 1'b0, 1'b0, got);
    endtask

    task automatic peek(input string tag, input logic [7:0] exp);
        @(negedge clk);
        check(tag, status_o, exp);
    endtask

    initial begin
        logic g;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_data = '0;
        wp_n = 1'b1; busy_i = 1'b0; op_done = 1'b0;
        m_wel = 0; m_winc = 0; m_lock = 0; m_armed = 0; m_bp = 3'b111;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        peek("R1 reset status", 8'h1C);
        check("R1 reset armed", sr_armed, 1'b0);
        busy_i = 1'b1;
        #1 check("R2 busy bit", status_o, 8'h1D);
        busy_i = 1'b0;

        cmd(8'h06, 0, 0, 1, g);
        peek("R3 latch set", 8'h1E);
        check("R4 armed by 06", sr_armed, 1'b1);
        cmd(8'h02, 19'h00000, 0, 1, g);
        check("R8 code 111 denies low", g, 1'b0);
        cmd(8'h04, 0, 0, 1, g);
        peek("R3 latch clear", 8'h1C);
        cmd(8'h01, 0, 8'h00, 1, g);
        peek("R5 unarmed write ignored", 8'h1C);
        cmd(8'h50, 0, 0, 1, g);
        cmd(8'h01, 0, 8'h00, 1, g);
        peek("R5 armed write", 8'h00);
        cmd(8'h50, 0, 0, 1, g);
        cmd(8'h05, 0, 0, 1, g);
        cmd(8'h01, 0, 8'h1C, 1, g);
        peek("R4 disarmed by other", 8'h00);

        cmd(8'h06, 0, 0, 1, g);
        cmd(8'h60, 19'h12345, 0, 1, g);
        check("R9 chip erase open", g, 1'b1);
        step(1'b0, 8'h00, 0, 0, 1, 0, 1, g);
        peek("R11 completion clears", 8'h00);

        for (int c = 1; c <= 3; c++) begin
            logic [18:0] below;
            below = (c == 1) ? 19'h6FFFF : (c == 2) ? 19'h5FFFF : 19'h3FFFF;
            cmd(8'h50, 0, 0, 1, g);
            cmd(8'h01, 0, 8'(c << 2), 1, g);
            cmd(8'h06, 0, 0, 1, g);
            cmd(8'h20, 19'h7FFFF, 0, 1, g);
            check("R8 top protected", g, 1'b0);
            cmd(8'hD8, below, 0, 1, g);
            check("R8 below boundary open", g, 1'b1);
            cmd(8'hC7, 19'h00000, 0, 1, g);
            check("R9 chip erase blocked", g, 1'b0);
        end
        cmd(8'h50, 0, 0, 1, g);
        cmd(8'h01, 0, 8'h10, 1, g);
        cmd(8'h06, 0, 0, 1, g);
        cmd(8'h02, 19'h00000, 0, 1, g);
        check("R8 code 100 whole array", g, 1'b0);

        cmd(8'h50, 0, 0, 1, g);
        cmd(8'h01, 0, 8'h00, 1, g);
        cmd(8'h06, 0, 0, 1, g);
        step(1'b1, 8'h02, 19'h00010, 0, 1, 1, 0, g);
        check("R10 busy denies", g, 1'b0);

        cmd(8'h50, 0, 0, 0, g);
        cmd(8'h01, 0, 8'h84, 0, g);
        peek("R6 lock and code together", 8'h84);
        cmd(8'h50, 0, 0, 0, g);
        cmd(8'h01, 0, 8'h00, 0, g);
        peek("R6 locked write rejected", 8'h84);
        cmd(8'h06, 0, 0, 0, g);
        cmd(8'h01, 0, 8'h00, 1, g);
        peek("R7 pin high overrides lock", 8'h00);

        cmd(8'h06, 0, 0, 1, g);
        cmd(8'hAD, 19'h00000, 0, 1, g);
        check("R12 word-increment granted", g, 1'b1);
        peek("R12 mode flag set", 8'h42);
        cmd(8'h04, 0, 0, 1, g);
        peek("R3 disable clears mode", 8'h00);

        begin
            int unsigned seed;
            logic [7:0] ops [12];
            seed = 32'd4242;
            ops = '{8'h01, 8'h02, 8'h04, 8'h06, 8'h20, 8'h50, 8'h60, 8'hAD,
                    8'hC7, 8'hD8, 8'h03, 8'h05};
            void'($urandom(seed));
            for (int i = 0; i < 800; i++) begin
                step(($urandom % 4) != 0, ops[$urandom % 12], 19'($urandom),
                     8'($urandom), 1'($urandom), ($urandom % 4) == 0,
                     ($urandom % 8) == 0, g);
            end
        end
        peek("R2 final status", {m_lock, m_winc, 1'b0, m_bp, m_wel, busy_i});

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule